// File: doc/BRIEF.md
# Register Bank with Atomic Bit-Update Aliases

This block holds two banks of 32-bit control registers and one fixed identification word behind a single request/response bus. Every register owns a 16-byte address window. The low nibble of the address selects what a write does to the register:

- replace the whole word;
- OR the data into it;
- AND the inverted data into it;
- XOR the data into it.

Software can therefore change individual bits without first reading the register. A read through any of the four aliases returns the same stored word.

The first bank (the "control" bank) loads a reset value per register from a parameter table. Selected registers in that bank carry a lock-status bit at bit 31 that always reads as 1. The second bank (the "auxiliary" bank) resets to zero. The identification word is read-only. Its window is decoded ahead of every other region, including an auxiliary window it overlaps. Malformed, unmapped or forbidden accesses return an error response and change nothing.

The bus accepts one request per cycle while `req_ready` is high. It answers each accepted request exactly one cycle later with `rsp_valid`, the read data and an error flag.

Top module: `scta_bank_top`

## Requirements
- R1: Registers sit 16 bytes apart: address window `addr[15:4]` selects the register. Control register i sits at 0x60 + 16*i for i < N_CTRL (8 by default). Auxiliary register j sits at 0x200 + 16*j for j < N_AUX (104 by default).
- R2: A write whose address low nibble is 0x0 replaces the register with `req_wdata`.
- R3: A write at low nibble 0x4 makes the register its old value OR `req_wdata`.
- R4: A write at low nibble 0x8 makes the register its old value AND NOT `req_wdata`.
- R5: A write at low nibble 0xC makes the register its old value XOR `req_wdata`.
- R6: A read at any of the four nibbles 0x0/0x4/0x8/0xC of a window returns the register's stored value.
- R7: Only word accesses are serviced. `req_size` encodes 2**size bytes, so 2'b10 is a word. Any other size gives an error response and no state change.
- R8: A low nibble whose two lowest bits are not zero (unaligned) gives an error response and no state change.
- R9: An address outside every mapped window gives an error response and no state change.
- R10: On reset, control register i loads CTRL_RST[i] and every auxiliary register loads zero.
- R11: The identification word at window 0x800 reads 0x00720010 through any alias. A write to it gives an error response and leaves it unchanged.
- R12: The identification window takes priority over auxiliary register 96, which overlaps it. The neighbouring auxiliary windows 0x7F0 and 0x810 still behave as ordinary registers.
- R13: In each control register whose CTRL_LOCK bit is set, bit 31 reads 1 after reset and after any write through any alias.
- R14: `req_ready` is low during reset and high otherwise. Each accepted request produces exactly one response one cycle later, with `rsp_err` set on errors. `rsp_rdata` is zero for writes and for errors, and no response appears without a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | AW (16) | Byte address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size, 2**size bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| rsp_err | output | 1 | Access rejected |

## Verification
The hardest case to reach is the interaction of the lock bit with the clear and toggle aliases, together with the identification window shadowing an auxiliary register. Both cases only show up when a write through one alias is followed by a read through a different alias of the same or a neighbouring window.

The stimulus drives directed clear-all and toggle-bit-31 writes on locked registers, and writes around the 0x800 overlap. It then runs a long pseudo-random stream of write/read pairs over both banks, with the alias drawn at random. A bench-side shadow model predicts every response from the rules above.

// File: rtl/scta_pkg.sv
package scta_pkg;

    parameter int unsigned DATA_W   = 32;
    parameter int unsigned LOCK_POS = DATA_W - 1;
    parameter logic [1:0]  SIZE_WORD = 2'b10;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_SET    = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_TOGGLE = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_CTRL = 2'd1,
        RGN_AUX  = 2'd2,
        RGN_ID   = 2'd3
    } region_e;

    typedef struct packed {
        region_e region;
        op_e     op;
        logic    err;
    } dec_t;

    function automatic logic [DATA_W-1:0] apply_op(
        input op_e               op,
        input logic [DATA_W-1:0] cur,
        input logic [DATA_W-1:0] d
    );
        case (op)
            OP_SET:    return cur | d;
            OP_CLEAR:  return cur & ~d;
            OP_TOGGLE: return cur ^ d;
            default:   return d;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] lock_force(input logic en);
        logic [DATA_W-1:0] m;
        m = '0;
        m[LOCK_POS] = en;
        return m;
    endfunction

endpackage

// File: rtl/scta_decoder.sv
module scta_decoder
    import scta_pkg::*;
#(
    parameter int unsigned AW        = 16,
    parameter int unsigned IW        = 7,
    parameter int unsigned N_CTRL    = 8,
    parameter int unsigned N_AUX     = 104,
    parameter int unsigned CTRL_BASE = 32'h60,
    parameter int unsigned AUX_BASE  = 32'h200,
    parameter int unsigned ID_ADDR   = 32'h800
) (
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [1:0]    size,
    output dec_t          dec,
    output logic [IW-1:0] idx
);
    localparam int unsigned CTRL_WIN = CTRL_BASE >> 4;
    localparam int unsigned AUX_WIN  = AUX_BASE >> 4;
    localparam int unsigned ID_WIN   = ID_ADDR >> 4;

    int unsigned win;
    logic        misaligned;

    always_comb begin
        win        = int'(addr[AW-1:4]);
        misaligned = (addr[1:0] != 2'b00);
        dec.op     = op_e'(addr[3:2]);
        idx        = '0;
        if (win == ID_WIN) begin
            dec.region = RGN_ID;
        end else if (win >= CTRL_WIN && win < CTRL_WIN + N_CTRL) begin
            dec.region = RGN_CTRL;
            idx        = IW'(win - CTRL_WIN);
        end else if (win >= AUX_WIN && win < AUX_WIN + N_AUX) begin
            dec.region = RGN_AUX;
            idx        = IW'(win - AUX_WIN);
        end else begin
            dec.region = RGN_NONE;
        end
        dec.err = misaligned || (size != SIZE_WORD) || (dec.region == RGN_NONE)
                  || (dec.region == RGN_ID && we);
    end
endmodule

// File: rtl/scta_regfile.sv
module scta_regfile
    import scta_pkg::*;
#(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = 7,
    parameter logic [N-1:0][DATA_W-1:0] RST_VALS  = '0,
    parameter logic [N-1:0]             LOCK_MASK = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  op_e               wr_op,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        localparam logic [DATA_W-1:0] FORCE = lock_force(LOCK_MASK[g]);
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= RST_VALS[g] | FORCE;
            end else if (wr_en && wr_idx == IW'(g)) begin
                regs[g] <= apply_op(wr_op, regs[g], wr_data) | FORCE;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N; i++) begin
            if (rd_idx == IW'(i)) rd_data = regs[i];
        end
    end
endmodule

// File: rtl/scta_bank_top.sv
module scta_bank_top
    import scta_pkg::*;
#(
    parameter int unsigned AW        = 16,
    parameter int unsigned N_CTRL    = 8,
    parameter int unsigned N_AUX     = 104,
    parameter int unsigned CTRL_BASE = 32'h60,
    parameter int unsigned AUX_BASE  = 32'h200,
    parameter int unsigned ID_ADDR   = 32'h800,
    parameter logic [DATA_W-1:0] ID_VALUE = 32'h0072_0010,
    parameter logic [N_CTRL-1:0][DATA_W-1:0] CTRL_RST = {
        32'h00A5_0003, 32'h0000_0000, 32'h0002_6419, 32'h0000_0F80,
        32'h1E2D_3C4B, 32'h0000_1800, 32'h0041_5A0E, 32'h0000_3C21},
    parameter logic [N_CTRL-1:0] CTRL_LOCK = 8'b1011_0101
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_addr,
    input  logic              req_we,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err
);
    localparam int unsigned NMAX = (N_AUX > N_CTRL) ? N_AUX : N_CTRL;
    localparam int unsigned IW   = (NMAX > 1) ? $clog2(NMAX) : 1;

    dec_t              dec;
    logic [IW-1:0]     idx;
    logic              accept;
    logic              wr_ok;
    logic [DATA_W-1:0] ctrl_rd, aux_rd, sel_rd;

    scta_decoder #(
        .AW(AW), .IW(IW), .N_CTRL(N_CTRL), .N_AUX(N_AUX),
        .CTRL_BASE(CTRL_BASE), .AUX_BASE(AUX_BASE), .ID_ADDR(ID_ADDR)
    ) dec_i (
        .addr(req_addr), .we(req_we), .size(req_size), .dec(dec), .idx(idx)
    );

    assign req_ready = ~rst;
    assign accept    = req_valid & req_ready;
    assign wr_ok     = accept & req_we & ~dec.err;

    scta_regfile #(
        .N(N_CTRL), .IW(IW), .RST_VALS(CTRL_RST), .LOCK_MASK(CTRL_LOCK)
    ) ctrl_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_ok && dec.region == RGN_CTRL),
        .wr_idx(idx), .wr_op(dec.op), .wr_data(req_wdata),
        .rd_idx(idx), .rd_data(ctrl_rd)
    );

    scta_regfile #(
        .N(N_AUX), .IW(IW), .RST_VALS('0), .LOCK_MASK('0)
    ) aux_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_ok && dec.region == RGN_AUX),
        .wr_idx(idx), .wr_op(dec.op), .wr_data(req_wdata),
        .rd_idx(idx), .rd_data(aux_rd)
    );

    always_comb begin
        case (dec.region)
            RGN_CTRL: sel_rd = ctrl_rd;
            RGN_AUX:  sel_rd = aux_rd;
            RGN_ID:   sel_rd = ID_VALUE;
            default:  sel_rd = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= accept;
            rsp_err   <= accept & dec.err;
            rsp_rdata <= (accept && !req_we && !dec.err) ? sel_rd : '0;
        end
    end
endmodule

// File: rtl/scta_bank_chk.sv
module scta_bank_chk
    import scta_pkg::*;
#(
    parameter int unsigned AW      = 16,
    parameter int unsigned ID_ADDR = 32'h800,
    parameter logic [DATA_W-1:0] ID_VALUE = 32'h0072_0010
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [AW-1:0]     req_addr,
    input logic              req_we,
    input logic [1:0]        req_size,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_err
);
    localparam logic [AW-5:0] ID_WIN = (AW-4)'(ID_ADDR >> 4);

    // R14
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    // R14
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !rsp_valid);

    // R14
    err_has_no_data_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));

    // R8
    misaligned_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_addr[1:0] != 2'b00) |=> rsp_err);

    // R7
    narrow_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_size != SIZE_WORD) |=> rsp_err);

    // R11
    id_read_value_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_we && req_addr[AW-1:4] == ID_WIN
         && req_addr[1:0] == 2'b00 && req_size == SIZE_WORD)
        |=> (!rsp_err && rsp_rdata == ID_VALUE));

    // R11
    id_write_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_we && req_addr[AW-1:4] == ID_WIN) |=> rsp_err);
endmodule

bind scta_bank_top scta_bank_chk #(
    .AW(AW), .ID_ADDR(ID_ADDR), .ID_VALUE(ID_VALUE)
) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_size(req_size),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
);

// File: tb/scta_bank_top_tb_top.sv
module scta_bank_top_tb_top;
    localparam logic [7:0][31:0] TB_RST = {
        32'h0000_00F1, 32'h7000_0001, 32'h0123_4567, 32'h0000_0000,
        32'h5555_0000, 32'h0000_AAAA, 32'hCAFE_0042, 32'h0000_2042};
    localparam logic [7:0] TB_LOCK = 8'b1001_0101;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic [1:0]  req_size = 2'b10;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;

    always #2 clk = ~clk;

    scta_bank_top #(.CTRL_RST(TB_RST), .CTRL_LOCK(TB_LOCK)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_we(req_we), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err)
    );

    typedef struct {
        logic        err;
        logic [31:0] rd;
        int          cyc;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] mdl [112];
    int          n_cmp = 0;
    int          n_bad = 0;
    int          cycle = 0;
    bit          done  = 0;

    always @(posedge clk) cycle <= cycle + 1;

    task automatic fail_line(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_bad++;
        $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) mdl[i] = TB_RST[i] | (TB_LOCK[i] ? 32'h8000_0000 : 32'h0);
        for (int i = 8; i < 112; i++) mdl[i] = '0;
    endtask

    // Driver: predicts and pushes, then drives one request cycle
    task automatic issue(input logic [15:0] a, input logic we, input logic [1:0] sz,
                         input logic [31:0] d, input string tag);
        exp_t e;
        int   w;
        int   slot;
        bit   is_id, is_ctrl, err;
        logic [31:0] cur;
        w = int'(a[15:4]);
        is_id = (w == 'h80);
        is_ctrl = 0;
        slot = -1;
        if (!is_id && w >= 6 && w < 14) begin slot = w - 6; is_ctrl = 1; end
        else if (!is_id && w >= 32 && w < 136) slot = 8 + (w - 32);
        err = (a[1:0] != 0) || (sz != 2'b10) || (!is_id && slot < 0) || (is_id && we);
        e.rd = '0;
        if (!err && we) begin
            cur = mdl[slot];
            case (a[3:2])
                2'd0: cur = d;
                2'd1: cur = cur | d;
                2'd2: cur = cur & ~d;
                default: cur = cur ^ d;
            endcase
            if (is_ctrl && TB_LOCK[slot]) cur[31] = 1'b1;
            mdl[slot] = cur;
        end else if (!err) begin
            e.rd = is_id ? 32'h0072_0010 : mdl[slot];
        end
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_we = we; req_size = sz; req_wdata = d;
        e.err = err; e.cyc = cycle; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input string tag);
        issue(a, 1'b0, 2'b10, 32'h0, tag);
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input string tag);
        issue(a, 1'b1, 2'b10, d, tag);
    endtask

    // Monitor: compares responses against the queue
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (rsp_valid) begin
                if (sb.size() == 0) begin
                    n_cmp++;
                    fail_line("R14 unexpected response", 32'(rsp_valid), 32'h0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    n_cmp++;
                    if (rsp_err !== e.err || rsp_rdata !== e.rd) begin
                        n_bad++;
                        $display("FAIL %s actual err=%b data=%h expected err=%b data=%h",
                                 e.tag, rsp_err, rsp_rdata, e.err, e.rd);
                    end
                end
            end else if (sb.size() > 0 && cycle > sb[0].cyc) begin
                exp_t e;
                e = sb.pop_front();
                n_cmp++;
                fail_line({e.tag, " R14 missing response"}, 32'h0, 32'h1);
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        n_cmp++;
        fail_line("watchdog expired", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        logic [15:0] lf;
        model_reset();
        repeat (3) @(negedge clk);
        n_cmp++; if (req_ready !== 1'b0) fail_line("R14 ready low in reset", 32'(req_ready), 32'h0);
        n_cmp++; if (rsp_valid !== 1'b0) fail_line("R14 no response in reset", 32'(rsp_valid), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        n_cmp++; if (req_ready !== 1'b1) fail_line("R14 ready after reset", 32'(req_ready), 32'h1);

        // R10 R13 reset contents
        for (int i = 0; i < 8; i++) rd(16'(32'h60 + 16 * i), "R10/R13 ctrl reset value");
        rd(16'h0200, "R10 aux0 reset zero");
        rd(16'h0520, "R10 aux50 reset zero");

        // R2 R6 plain write, read through every alias
        wr(16'h0070, 32'h1234_5678, "R2 plain write");
        rd(16'h0070, "R6 alias0");
        rd(16'h0074, "R6 alias4");
        rd(16'h0078, "R6 alias8");
        rd(16'h007C, "R6 aliasC");

        // R3 R4 R5 on an unlocked register
        wr(16'h0094, 32'h0F0F_0000, "R3 set");
        rd(16'h0090, "R3 readback");
        wr(16'h0098, 32'h00FF_00FF, "R4 clear");
        rd(16'h0090, "R4 readback");
        wr(16'h009C, 32'hFFFF_0000, "R5 toggle");
        rd(16'h0090, "R5 readback");

        // R13 lock bit survives every alias
        wr(16'h0060, 32'h0000_0000, "R13 plain zero locked");
        rd(16'h0060, "R13 readback plain");
        wr(16'h0088, 32'hFFFF_FFFF, "R13 clear all locked");
        rd(16'h0080, "R13 readback clear");
        wr(16'h00AC, 32'h8000_0000, "R13 toggle lock bit");
        rd(16'h00A0, "R13 readback toggle");

        // R8 misaligned nibbles
        wr(16'h0072, 32'hDEAD_BEEF, "R8 nibble 2 write");
        wr(16'h0071, 32'hDEAD_BEEF, "R8 nibble 1 write");
        rd(16'h0073, "R8 nibble 3 read");
        rd(16'h0070, "R8 unchanged");

        // R7 narrow sizes
        issue(16'h0070, 1'b1, 2'b00, 32'h0000_00AA, "R7 byte write");
        issue(16'h0070, 1'b1, 2'b01, 32'h0000_AAAA, "R7 half write");
        issue(16'h0070, 1'b0, 2'b11, 32'h0, "R7 dword read");
        rd(16'h0070, "R7 unchanged");

        // R9 unmapped
        wr(16'h0000, 32'h1, "R9 below ctrl");
        wr(16'h00E0, 32'h1, "R9 after ctrl");
        rd(16'h0100, "R9 gap read");
        wr(16'h0880, 32'h1, "R9 after aux");
        rd(16'h0900, "R9 high read");

        // R11 R12 identification word and overlap
        rd(16'h0800, "R11 id alias0");
        rd(16'h0804, "R11 id alias4");
        rd(16'h080C, "R11 id aliasC");
        wr(16'h0800, 32'hFFFF_FFFF, "R11 id plain write");
        wr(16'h0808, 32'hFFFF_FFFF, "R11 id clear write");
        rd(16'h0808, "R11 id unchanged");
        wr(16'h07F0, 32'hA1A1_0001, "R12 aux95 write");
        wr(16'h081C, 32'h0000_F00F, "R12 aux97 toggle");
        rd(16'h07F4, "R12 aux95 read");
        rd(16'h0810, "R12 aux97 read");
        rd(16'h0800, "R12 id wins overlap");

        // R1 bank edges
        wr(16'h00D0, 32'h7777_0000, "R1 last ctrl");
        rd(16'h00D8, "R1 last ctrl read");
        wr(16'h0870, 32'h0BAD_F00D, "R1 last aux");
        rd(16'h0870, "R1 last aux read");
        rd(16'h0200, "R1 aux0 untouched");

        // R2-R6 pseudo-random stream, idle gaps for R14
        lf = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            logic [15:0] a;
            logic [31:0] d;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            d  = {lf, lf ^ 16'h5A3C} ^ (32'(i) << 7);
            if (lf[0]) a = 16'(32'h60 + 16 * (lf[9:7]));
            else       a = 16'(32'h200 + 16 * (int'(lf[15:9]) % 104));
            wr(a | 16'({lf[5:4], 2'b00}), d, "R3/R4/R5 random write");
            rd(a | 16'({lf[12:11], 2'b00}), "R6 random read");
            if (lf[3:1] == 3'b000) idle();
        end
        idle();
        repeat (4) @(negedge clk);
        n_cmp++;
        if (sb.size() != 0) fail_line("R14 outstanding responses", 32'(sb.size()), 32'h0);
        finish_run();
    end
endmodule